// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between two asynchronous external interrupt pins and a downstream interrupt controller that only understands active-high levels and rising edges. Each pin is brought into the clock domain through a synchronizer and then interpreted according to its own configuration register. A line can sense a level or an edge, and a polarity bit picks which level or which edge counts. The result is always presented downstream in normalized form: a high level for a level-sensed line, or a one-clock high pulse for an edge-sensed line.

Software reaches the block through a simple register bus. Reads are combinational and take effect in the same cycle. Writes take effect at the clock edge on which they are presented. A status register reports when the sensing configuration has settled after reset or after the last configuration change.

In the polarity bit, a set value selects active-high in level mode but selects the falling edge in edge mode. Rewriting a configuration register reloads that line's edge history, so a configuration change never creates a pulse by itself.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset both outputs are low and both configuration registers read zero, so each line is disabled and set for rising-edge sensing.
- R2: The status register is at byte offset 0x00. The configuration of line 0 is at 0x04 and that of line 1 is at 0x08. In a configuration register, bit 16 is enable, bit 9 selects level sensing when 1 (edge when 0), and bit 8 is polarity. All other bits read back as zero.
- R3: In level mode with enable set, the output is high while the pin is high if bit 8 is 1, or while the pin is low if bit 8 is 0. A pin change sampled at one rising clock edge reaches the output after the second rising edge that follows.
- R4: In edge mode with bit 8 clear, a low-to-high pin transition gives exactly one high output cycle, at the same latency as R3. A high-to-low transition gives no pulse.
- R5: In edge mode with bit 8 set, a high-to-low pin transition gives exactly one high output cycle. A low-to-high transition gives no pulse.
- R6: While a line's enable bit is 0, its output stays low whatever its pin does.
- R7: Writing a configuration register never produces an output pulse by itself. This holds when an edge-mode line is enabled while its pin already stands at the level that its sensed edge would reach.
- R8: Status bit 0 reads 0 until SETTLE_CYCLES clocks (default 4) have passed since reset or since the last configuration write, and 1 from then on.
- R9: Writes to the status register and to unmapped offsets change no register and do not restart the R8 count. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational, zero when busEn is low |
| extPin | input | 2 | Asynchronous external interrupt pins |
| irqOut | output | 2 | Normalized per-line outputs to the interrupt controller |

## Verification
A table covers the level and disable behaviour. It drives each line through both polarities with the pin high and low, which separates correct polarity handling from an inverted or ignored polarity bit. It also shows that enable gates the output.

Edge tests apply rising and falling transitions under each polarity and count the output pulses. This catches width errors, sensing on the wrong edge and wrong latency.

A separate case lets a pin rise while its line is disabled and then enables rising-edge sensing. Only the history reload keeps the output quiet there. The status tests time the settle count and check that writes to the status register and to unmapped offsets are ignored.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int LINE_COUNT = 2;
  localparam int EN_BIT     = 16;
  localparam int LVL_BIT    = 9;
  localparam int POL_BIT    = 8;

  // Control-to-datapath bundle: per-line configuration and history reloads
  typedef struct packed {
    logic [LINE_COUNT-1:0] lineEn;
    logic [LINE_COUNT-1:0] lineLevel;
    logic [LINE_COUNT-1:0] linePol;
    logic [LINE_COUNT-1:0] histReload;
  } ctlStrobes_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output ctlStrobes_t       ctl,
  output logic              statusReady
);
  localparam int CNT_W      = $clog2(SETTLE_CYCLES + 1);
  localparam int STAT_OFF   = 0;
  localparam int CFG_BASE   = 4;
  localparam int CFG_STRIDE = 4;

  logic [LINE_COUNT-1:0] enQ, lvlQ, polQ;
  logic [LINE_COUNT-1:0] cfgHit;
  logic [CNT_W-1:0]      settleCnt;
  logic                  unusedWdata;

  genvar gi;
  generate
    for (gi = 0; gi < LINE_COUNT; gi++) begin : g_dec
      assign cfgHit[gi] = busEn && busWr &&
                          (busAddr == ADDR_W'(CFG_BASE + CFG_STRIDE * gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      lvlQ <= '0;
      polQ <= '0;
    end else begin
      for (int i = 0; i < LINE_COUNT; i++) begin
        if (cfgHit[i]) begin
          enQ[i]  <= busWdata[EN_BIT];
          lvlQ[i] <= busWdata[LVL_BIT];
          polQ[i] <= busWdata[POL_BIT];
        end
      end
    end
  end

  // Settle counter restarts on any configuration write
  always_ff @(posedge clk) begin
    if (!rstN)                                 settleCnt <= '0;
    else if (|cfgHit)                          settleCnt <= '0;
    else if (settleCnt != CNT_W'(SETTLE_CYCLES)) settleCnt <= settleCnt + 1'b1;
  end

  assign statusReady = (settleCnt == CNT_W'(SETTLE_CYCLES));

  always_comb begin
    busRdata = '0;
    if (busEn) begin
      if (busAddr == ADDR_W'(STAT_OFF)) busRdata[0] = statusReady;
      for (int i = 0; i < LINE_COUNT; i++) begin
        if (busAddr == ADDR_W'(CFG_BASE + CFG_STRIDE * i)) begin
          busRdata[EN_BIT]  = enQ[i];
          busRdata[LVL_BIT] = lvlQ[i];
          busRdata[POL_BIT] = polQ[i];
        end
      end
    end
  end

  assign ctl.lineEn     = enQ;
  assign ctl.lineLevel  = lvlQ;
  assign ctl.linePol    = polQ;
  assign ctl.histReload = cfgHit;

  assign unusedWdata = ^{busWdata[DATA_W-1:EN_BIT+1], busWdata[EN_BIT-1:LVL_BIT+1],
                         busWdata[POL_BIT-1:0]};
endmodule

// File: rtl/ext_irq_lines.sv
module ext_irq_lines
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] extPin,
  input  ctlStrobes_t           ctl,
  output logic [LINE_COUNT-1:0] irqOut
);
  genvar gi;
  generate
    for (gi = 0; gi < LINE_COUNT; gi++) begin : g_line
      logic syncPin, hist, edgeActive, riseSeen, fallSeen, levelHit, nextOut;

      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rstN(rstN),
        .din (extPin[gi]),
        .dout(syncPin)
      );

      assign edgeActive = ctl.lineEn[gi] && !ctl.lineLevel[gi];

      // History follows the pin only while edge sensing; a config write reloads it
      always_ff @(posedge clk) begin
        if (!rstN)                              hist <= 1'b0;
        else if (ctl.histReload[gi] || edgeActive) hist <= syncPin;
      end

      assign riseSeen = syncPin && !hist;
      assign fallSeen = !syncPin && hist;
      assign levelHit = syncPin ~^ ctl.linePol[gi];
      assign nextOut  = ctl.lineEn[gi] &&
                        (ctl.lineLevel[gi] ? levelHit
                                           : (ctl.linePol[gi] ? fallSeen : riseSeen));

      always_ff @(posedge clk) begin
        if (!rstN) irqOut[gi] <= 1'b0;
        else       irqOut[gi] <= nextOut;
      end
    end
  endgenerate
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int SETTLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busEn,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [LINE_COUNT-1:0] extPin,
  output logic [LINE_COUNT-1:0] irqOut
);
  ctlStrobes_t ctl;
  logic        statusReady;

  ext_irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_regs (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ctl(ctl), .statusReady(statusReady)
  );

  ext_irq_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rstN(rstN), .extPin(extPin), .ctl(ctl), .irqOut(irqOut)
  );
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [LINE_COUNT-1:0] extPin,
  input logic [LINE_COUNT-1:0] irqOut,
  input ctlStrobes_t           ctl,
  input logic                  statusReady
);
  localparam int WAIT_W = $clog2(SETTLE_CYCLES + 1) + 1;

  logic [1:0]        warmCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              anyWrite;

  assign anyWrite = |ctl.histReload;

  always_ff @(posedge clk) begin
    if (!rstN)               warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                   waitCnt <= '0;
    else if (anyWrite)                           waitCnt <= '0;
    else if (waitCnt < WAIT_W'(SETTLE_CYCLES))   waitCnt <= waitCnt + 1'b1;
  end

  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyWrite |=> !statusReady);
  assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusReady && !anyWrite) |=> statusReady);
  assert_ready_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusReady |-> (waitCnt >= WAIT_W'(SETTLE_CYCLES)));

  genvar gi;
  generate
    for (gi = 0; gi < LINE_COUNT; gi++) begin : g_chk
      logic [2:0] cfgBits;
      assign cfgBits = {ctl.lineEn[gi], ctl.lineLevel[gi], ctl.linePol[gi]};

      assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt == 2'd3 && $past(!ctl.lineEn[gi])) |-> !irqOut[gi]);

      assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt == 2'd3 && $past(ctl.lineEn[gi] && ctl.lineLevel[gi]))
          |-> (irqOut[gi] == ($past(extPin[gi], 3) ~^ $past(ctl.linePol[gi]))));

      assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
        (irqOut[gi] && ctl.lineEn[gi] && !ctl.lineLevel[gi] && $stable(cfgBits))
          |=> !irqOut[gi]);
    end
  endgenerate
endmodule

bind ext_irq_cond ext_irq_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .extPin(extPin), .irqOut(irqOut),
  .ctl(ctl), .statusReady(statusReady)
);

// File: tb/tb_ext_irq_cond.sv
`timescale 1ns/1ps
module tb_ext_irq_cond;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busEn = 1'b0, busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [1:0]        extPin = 2'b00;
  logic [1:0]        irqOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  ext_irq_cond dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extPin(extPin), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  // {line, en, lvl, pol, pin, expected}
  localparam int NVEC = 12;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_1_1_1_1_1, 6'b0_1_1_1_0_0, 6'b0_1_1_0_0_1, 6'b0_1_1_0_1_0,
    6'b0_0_1_0_0_0, 6'b0_0_1_1_1_0,
    6'b1_1_1_1_1_1, 6'b1_1_1_0_1_0, 6'b1_1_1_0_0_1, 6'b1_0_1_1_1_0,
    6'b1_1_0_0_1_0, 6'b0_1_0_1_0_0
  };

  function automatic logic [DATA_W-1:0] cfgWord(logic en, logic lvl, logic pol);
    cfgWord = (DATA_W'(en) << 16) | (DATA_W'(lvl) << 9) | (DATA_W'(pol) << 8);
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    busEn = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    busEn = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busEn = 1'b0;
  endtask

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic countHighs(int line, int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (irqOut[line]) hits++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int hits;
    cycles(3);
    rstN = 1'b1;
    // R1 / R8 reset state
    check("R1 outputs", DATA_W'(irqOut), 0);
    busRead(8'h04, rd); check("R1 cfg0", rd, 0);
    busRead(8'h08, rd); check("R1 cfg1", rd, 0);
    busRead(8'h00, rd); check("R8 not ready at reset", rd, 0);
    cycles(5);
    busRead(8'h00, rd); check("R8 ready after settle", rd, 1);

    // R2 field positions and reserved bits
    busWrite(8'h04, '1);
    busRead(8'h04, rd); check("R2 cfg0 readback", rd, 32'h0001_0300);
    busRead(8'h08, rd); check("R2 cfg1 untouched", rd, 0);
    busRead(8'h00, rd); check("R8 cleared by write", rd, 0);
    cycles(3);
    busRead(8'h00, rd); check("R8 still waiting", rd, 0);
    cycles(1);
    busRead(8'h00, rd); check("R8 ready after count", rd, 1);
    busWrite(8'h04, 0);

    // Table walk: R3 level polarity, R6 enable gating
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] e;
      e = VEC[v];
      busWrite(e[5] ? 8'h08 : 8'h04, cfgWord(e[4], e[3], e[2]));
      extPin = 2'b00;
      extPin[e[5]] = e[1];
      cycles(5);
      check(e[4] ? (e[3] ? "R3 level vector" : "R4 edge steady vector") : "R6 disabled vector",
            DATA_W'(irqOut[e[5]]), DATA_W'(e[0]));
    end
    busWrite(8'h04, 0); busWrite(8'h08, 0); extPin = 2'b00; cycles(4);

    // R4 rising edge: latency and single pulse
    busWrite(8'h04, cfgWord(1, 0, 0));
    cycles(4);
    extPin[0] = 1'b1;
    cycles(2);
    check("R4 no pulse before latency", DATA_W'(irqOut[0]), 0);
    cycles(1);
    check("R4 pulse on rise", DATA_W'(irqOut[0]), 1);
    cycles(1);
    check("R4 pulse width one", DATA_W'(irqOut[0]), 0);
    extPin[0] = 1'b0;
    countHighs(0, 6, hits);
    check("R4 no pulse on fall", DATA_W'(hits), 0);

    // R5 falling edge
    busWrite(8'h04, cfgWord(1, 0, 1));
    cycles(3);
    extPin[0] = 1'b1;
    countHighs(0, 6, hits);
    check("R5 no pulse on rise", DATA_W'(hits), 0);
    extPin[0] = 1'b0;
    cycles(3);
    check("R5 pulse on fall", DATA_W'(irqOut[0]), 1);
    countHighs(0, 4, hits);
    check("R5 single pulse", DATA_W'(hits), 0);

    // R6 edge input while disabled
    busWrite(8'h04, 0);
    extPin[0] = 1'b1;
    countHighs(0, 6, hits);
    check("R6 disabled edge ignored", DATA_W'(hits), 0);
    extPin[0] = 1'b0;
    cycles(4);

    // R7 enabling with stale history must not pulse
    extPin[1] = 1'b1;
    cycles(6);
    busWrite(8'h08, cfgWord(1, 0, 0));
    countHighs(1, 6, hits);
    check("R7 no pulse on config write", DATA_W'(hits), 0);
    extPin[1] = 1'b0; cycles(4);
    extPin[1] = 1'b1;
    countHighs(1, 6, hits);
    check("R7 real edge still seen", DATA_W'(hits), 1);

    // R9 ignored writes and unmapped reads
    cycles(5);
    busWrite(8'h00, '0);
    busRead(8'h00, rd); check("R9 status write ignored", rd, 1);
    busWrite(8'h0C, '1);
    busRead(8'h0C, rd); check("R9 unmapped read zero", rd, 0);
    busRead(8'h04, rd); check("R9 cfg0 unchanged", rd, 0);
    busRead(8'h08, rd); check("R9 cfg1 unchanged", rd, 32'h0001_0000);
    busRead(8'h00, rd); check("R9 settle not restarted", rd, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule